// File: doc/BRIEF.md
# Serial Link Transmit Character Selector

This block sits in front of an 8B/10B encoder and, on every rising edge of the byte clock, chooses the character the encoder codes next. It works from a parallel byte and a control-character select bit. It also takes a violation request, two active-low load enables with different latency, a self-test enable and an encoder-bypass mode bit. From these it produces a character kind with an 8-bit value for the encoder, or a 10-bit raw word that skips the encoder. It also drives a byte-rate, active-low read strobe that an upstream FIFO uses to pop its next entry.

When neither enable asks for a byte, the line is filled with the K28.5 idle character, so the link never runs dry. A violation request overrides everything except bypass. With self-test on, the block either alternates two fixed data characters or walks a 127-byte pseudo-random loop. The loop is produced by a 7-bit LFSR, and the read strobe marks its last byte.

Top module: `tx_char_sel`

## Requirements
- R1: While synchronous reset is high, and after the edge that applies it, charKind is 2 (fill), charValue is 0xBC, readStrobeN is 1 and rawValid is 0. The next-edge pending flag and the alternation phase clear, and the LFSR returns to its seed 0x01.
- R2: charKind encodes 0 = data, 1 = special (K), 2 = fill, 3 = violation. All outputs are registered and reflect the inputs of the previous rising edge. In normal mode (testEn low, bypassMode low), loadNowN low at an edge loads dataIn from that same edge into charValue. It also drives readStrobeN low for that one byte; otherwise readStrobeN is high.
- R3: loadNextN low at an edge loads the dataIn and specialSel present at the following edge. The load happens even if both enables are high at that following edge.
- R4: With no load due (loadNowN high and no pending next-edge load), dataIn and specialSel are ignored. The output is kind 2 with value 0xBC.
- R5: For a loaded byte, specialSel high gives kind 1 and low gives kind 0, with charValue equal to the byte.
- R6: sendViol high at an edge (bypass off) gives kind 3 with value 0x00, whatever the enables, data or self-test state.
- R7: With testEn high and no load due, the output is kind 0, alternating 0x4A and 0xB5. After reset the first value is 0x4A.
- R8: With testEn high and a load due, the output steps the LFSR sequence. The LFSR shifts left, and its new bit 0 is bit6 XOR bit5, giving a period of 127. At the seed state the output is kind 1, value 0xBC. At every other state it is kind 0, value {1'b0, state}.
- R9: sendViol high while testEn is high returns the LFSR to its seed, so the next sequence byte is the kind 1 start marker.
- R10: With testEn high, readStrobeN is low only for the sequence byte whose successor state is the seed: once per 127-byte loop.
- R11: With bypassMode high, rawWord takes {sendViol, specialSel, dataIn} (bit 9 = sendViol, bit 8 = specialSel) and rawValid is 1. charKind shows fill. With bypassMode low, rawValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 8 | Parallel byte |
| specialSel | input | 1 | 1 = control character, 0 = data character |
| sendViol | input | 1 | Force a violation symbol |
| loadNowN | input | 1 | Active-low load of the byte at this edge |
| loadNextN | input | 1 | Active-low load of the byte at the next edge |
| testEn | input | 1 | Self-test pattern enable |
| bypassMode | input | 1 | Pass a raw 10-bit word around the encoder |
| charKind | output | 2 | Character kind for the encoder |
| charValue | output | 8 | Character value for the encoder |
| rawWord | output | 10 | Unencoded word in bypass mode |
| rawValid | output | 1 | rawWord is current |
| readStrobeN | output | 1 | Active-low byte-rate FIFO read strobe |

## Verification
The hardest point to reach from the ports is the single byte at the end of the 127-byte self-test loop, where the read strobe drops. The stimulus holds the self-test enable and a load enable for more than a full loop from a fresh reset. A bench-side LFSR predicts every byte and the exact cycle of the strobe, and the same run then checks the wrap back to the start marker. The violation restart is reached mid-loop, so that a sequence that failed to restart would show a data byte instead of the marker.

// File: rtl/tx_sel_pkg.sv
package tx_sel_pkg;

  typedef enum logic [1:0] {
    KIND_DATA    = 2'd0,
    KIND_SPECIAL = 2'd1,
    KIND_FILL    = 2'd2,
    KIND_VIOL    = 2'd3
  } charKind_e;

  localparam logic [7:0] FILL_CODE = 8'hBC;  // K28.5
  localparam logic [7:0] ALT_EVEN  = 8'h4A;  // D10.2
  localparam logic [7:0] ALT_ODD   = 8'hB5;  // D21.5
  localparam logic [7:0] VIOL_CODE = 8'h00;

  // Strobes from control to datapath, one decision per byte clock.
  typedef struct packed {
    logic bypass;
    logic viol;
    logic testSeq;
    logic testAlt;
    logic altOdd;
    logic load;
    logic seqStart;
    logic strobeLow;
  } selStrobes_t;

endpackage

// File: rtl/tx_sel_ctrl.sv
module tx_sel_ctrl
  import tx_sel_pkg::*;
#(
  parameter int               LFSR_W = 7,
  parameter logic [LFSR_W-1:0] SEED  = 7'h01,
  parameter int               TAP_A  = 6,
  parameter int               TAP_B  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadNowN,
  input  logic              loadNextN,
  input  logic              sendViol,
  input  logic              testEn,
  input  logic              bypassMode,
  output selStrobes_t       st,
  output logic [LFSR_W-1:0] lfsrState
);

  logic              pendingQ;
  logic              altQ;
  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNext;
  logic              loadDue;
  logic              encoded;

  always_comb begin
    lfsrNext = {lfsrQ[LFSR_W-2:0], lfsrQ[TAP_A] ^ lfsrQ[TAP_B]};
    loadDue  = !loadNowN || pendingQ;
    encoded  = !bypassMode && !sendViol;

    st.bypass    = bypassMode;
    st.viol      = !bypassMode && sendViol;
    st.testSeq   = encoded && testEn && loadDue;
    st.testAlt   = encoded && testEn && !loadDue;
    st.load      = encoded && !testEn && loadDue;
    st.altOdd    = altQ;
    st.seqStart  = (lfsrQ == SEED);
    st.strobeLow = testEn ? (st.testSeq && (lfsrNext == SEED)) : !loadNowN;
  end

  assign lfsrState = lfsrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ <= 1'b0;
      altQ     <= 1'b0;
      lfsrQ    <= SEED;
    end else begin
      pendingQ <= !loadNextN;
      if (st.testAlt) altQ <= !altQ;
      if (!bypassMode && testEn && sendViol) lfsrQ <= SEED;
      else if (st.testSeq)                  lfsrQ <= lfsrNext;
    end
  end

  // R3: a next-edge request always produces a load decision (or is overridden)
  a_r3_next_edge_load: assert property (@(posedge clk) disable iff (rst)
    !loadNextN |=> (st.load || st.testSeq || st.viol || st.bypass));

  // R9: violation during self-test returns the sequence to its start
  a_r9_restart_seed: assert property (@(posedge clk) disable iff (rst)
    (testEn && sendViol && !bypassMode) |=> (lfsrQ == SEED));

  // R8: the LFSR never locks up in the all-zero state
  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsrQ != '0);

endmodule

// File: rtl/tx_sel_dp.sv
module tx_sel_dp
  import tx_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 7,
  localparam int RAW_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  selStrobes_t       st,
  input  logic [LFSR_W-1:0] lfsrState,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              specialSel,
  input  logic              sendViol,
  output charKind_e         charKind,
  output logic [DATA_W-1:0] charValue,
  output logic [RAW_W-1:0]  rawWord,
  output logic              rawValid,
  output logic              readStrobeN
);

  charKind_e         kindNext;
  logic [DATA_W-1:0] valueNext;

  always_comb begin
    kindNext  = KIND_FILL;
    valueNext = DATA_W'(FILL_CODE);
    if (st.bypass) begin
      kindNext  = KIND_FILL;
      valueNext = DATA_W'(FILL_CODE);
    end else if (st.viol) begin
      kindNext  = KIND_VIOL;
      valueNext = DATA_W'(VIOL_CODE);
    end else if (st.testSeq) begin
      kindNext  = st.seqStart ? KIND_SPECIAL : KIND_DATA;
      valueNext = st.seqStart ? DATA_W'(FILL_CODE) : DATA_W'(lfsrState);
    end else if (st.testAlt) begin
      kindNext  = KIND_DATA;
      valueNext = st.altOdd ? DATA_W'(ALT_ODD) : DATA_W'(ALT_EVEN);
    end else if (st.load) begin
      kindNext  = specialSel ? KIND_SPECIAL : KIND_DATA;
      valueNext = dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      charKind    <= KIND_FILL;
      charValue   <= DATA_W'(FILL_CODE);
      rawWord     <= '0;
      rawValid    <= 1'b0;
      readStrobeN <= 1'b1;
    end else begin
      charKind    <= kindNext;
      charValue   <= valueNext;
      rawValid    <= st.bypass;
      readStrobeN <= !st.strobeLow;
      if (st.bypass) rawWord <= {sendViol, specialSel, dataIn};
    end
  end

  // R6: a violation decision shows up as a violation character
  a_r6_violation_out: assert property (@(posedge clk) disable iff (rst)
    st.viol |=> (charKind == KIND_VIOL && charValue == DATA_W'(VIOL_CODE)));

  // R4: with nothing to send, the fill character goes out
  a_r4_fill_out: assert property (@(posedge clk) disable iff (rst)
    (!st.bypass && !st.viol && !st.testSeq && !st.testAlt && !st.load)
      |=> (charKind == KIND_FILL && charValue == DATA_W'(FILL_CODE)));

  // R7: an even alternation phase emits the first pattern
  a_r7_alt_even: assert property (@(posedge clk) disable iff (rst)
    (st.testAlt && !st.altOdd) |=> (charValue == DATA_W'(ALT_EVEN)));

  // R11: bypass captures the raw pins unchanged
  a_r11_bypass_raw: assert property (@(posedge clk) disable iff (rst)
    st.bypass |=> (rawValid && rawWord == $past({sendViol, specialSel, dataIn})));

endmodule

// File: rtl/tx_char_sel.sv
module tx_char_sel
  import tx_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 7,
  parameter logic [LFSR_W-1:0] SEED = 7'h01,
  localparam int RAW_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              specialSel,
  input  logic              sendViol,
  input  logic              loadNowN,
  input  logic              loadNextN,
  input  logic              testEn,
  input  logic              bypassMode,
  output logic [1:0]        charKind,
  output logic [DATA_W-1:0] charValue,
  output logic [RAW_W-1:0]  rawWord,
  output logic              rawValid,
  output logic              readStrobeN
);

  selStrobes_t       strobes;
  logic [LFSR_W-1:0] lfsrState;
  charKind_e         kindQ;

  tx_sel_ctrl #(
    .LFSR_W(LFSR_W),
    .SEED  (SEED),
    .TAP_A (LFSR_W - 1),
    .TAP_B (LFSR_W - 2)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .loadNowN  (loadNowN),
    .loadNextN (loadNextN),
    .sendViol  (sendViol),
    .testEn    (testEn),
    .bypassMode(bypassMode),
    .st        (strobes),
    .lfsrState (lfsrState)
  );

  tx_sel_dp #(
    .DATA_W(DATA_W),
    .LFSR_W(LFSR_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .st         (strobes),
    .lfsrState  (lfsrState),
    .dataIn     (dataIn),
    .specialSel (specialSel),
    .sendViol   (sendViol),
    .charKind   (kindQ),
    .charValue  (charValue),
    .rawWord    (rawWord),
    .rawValid   (rawValid),
    .readStrobeN(readStrobeN)
  );

  assign charKind = kindQ;

endmodule

// File: tb/tx_char_sel_tb_top.sv
module tx_char_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dataIn = '0;
  logic       specialSel = 1'b0;
  logic       sendViol = 1'b0;
  logic       loadNowN = 1'b1;
  logic       loadNextN = 1'b1;
  logic       testEn = 1'b0;
  logic       bypassMode = 1'b0;
  logic [1:0] charKind;
  logic [7:0] charValue;
  logic [9:0] rawWord;
  logic       rawValid;
  logic       readStrobeN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx_char_sel dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .specialSel(specialSel),
    .sendViol(sendViol), .loadNowN(loadNowN), .loadNextN(loadNextN),
    .testEn(testEn), .bypassMode(bypassMode), .charKind(charKind),
    .charValue(charValue), .rawWord(rawWord), .rawValid(rawValid),
    .readStrobeN(readStrobeN)
  );

  // {loadNowN, loadNextN, specialSel, sendViol, dataIn, expKind, expValue, expStrobeN}
  // normal mode; kinds: 0 data, 1 special, 2 fill, 3 violation
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 2'd2, 8'hBC, 1'b1},  // R4 idle fill
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 2'd0, 8'h3C, 1'b0},  // R2 current-edge data
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hBC, 2'd1, 8'hBC, 1'b0},  // R5 special
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 2'd2, 8'hBC, 1'b1},  // R3 request, no load yet
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hA7, 2'd0, 8'hA7, 1'b1},  // R3 loads this edge's byte
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h12, 2'd2, 8'hBC, 1'b1},  // R4
    {1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 2'd3, 8'h00, 1'b0},  // R6 overrides load
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h34, 2'd3, 8'h00, 1'b1},  // R6
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 2'd2, 8'hBC, 1'b1},  // R3 request
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h7C, 2'd1, 8'h7C, 1'b1},  // R3 R5 delayed special
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 2'd0, 8'h01, 1'b0},  // R2 plus new request
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h02, 2'd3, 8'h00, 1'b1},  // R6 beats pending load
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h99, 2'd2, 8'hBC, 1'b1}   // R4 specialSel ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleInputs;
    dataIn = '0; specialSel = 1'b0; sendViol = 1'b0;
    loadNowN = 1'b1; loadNextN = 1'b1; testEn = 1'b0; bypassMode = 1'b0;
  endtask

  task automatic doReset;
    idleInputs();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  function automatic logic [6:0] lfsrStep(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  task automatic finishRun;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [6:0] s;
    int lowCount;
    @(negedge clk);
    doReset();

    // R1 reset state
    check("R1 kind", charKind, 2'd2);
    check("R1 value", charValue, 8'hBC);
    check("R1 strobe", readStrobeN, 1'b1);
    check("R1 rawValid", rawValid, 1'b0);

    // R2 R3 R4 R5 R6 vector table
    for (int i = 0; i < NVEC; i++) begin
      {loadNowN, loadNextN, specialSel, sendViol, dataIn} = VEC[i][22:11];
      tick();
      check($sformatf("R2/R3/R4/R5/R6 row %0d kind", i), charKind, VEC[i][10:9]);
      check($sformatf("R2/R3/R4/R5/R6 row %0d value", i), charValue, VEC[i][8:1]);
      check($sformatf("R2 row %0d strobe", i), readStrobeN, VEC[i][0]);
    end

    // R7 alternation, data inputs ignored
    doReset();
    testEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      dataIn = 8'(k * 37);
      specialSel = k[0];
      tick();
      check("R7 kind", charKind, 2'd0);
      check("R7 value", charValue, (k % 2 == 0) ? 8'h4A : 8'hB5);
      check("R10 strobe high in alternation", readStrobeN, 1'b1);
    end
    sendViol = 1'b1;
    tick();
    check("R6 over alternation", charKind, 2'd3);
    sendViol = 1'b0;

    // R8 R10 full loop and wrap
    doReset();
    testEn = 1'b1;
    loadNowN = 1'b0;
    s = 7'h01;
    lowCount = 0;
    for (int k = 0; k < 128; k++) begin
      tick();
      check("R8 kind", charKind, (s == 7'h01) ? 2'd1 : 2'd0);
      check("R8 value", charValue, (s == 7'h01) ? 8'hBC : {1'b0, s});
      check("R10 strobe", readStrobeN, (lfsrStep(s) == 7'h01) ? 1'b0 : 1'b1);
      if (readStrobeN == 1'b0) lowCount++;
      s = lfsrStep(s);
    end
    check("R10 one low per loop", lowCount, 1);

    // R9 restart mid-loop
    repeat (5) tick();
    sendViol = 1'b1;
    tick();
    check("R6 over self-test", charKind, 2'd3);
    sendViol = 1'b0;
    tick();
    check("R9 restart marker kind", charKind, 2'd1);
    check("R9 restart marker value", charValue, 8'hBC);
    tick();
    check("R9 restart second byte", charValue, {1'b0, lfsrStep(7'h01)});

    // R11 bypass
    doReset();
    bypassMode = 1'b1;
    loadNowN = 1'b0;
    dataIn = 8'h5A; specialSel = 1'b1; sendViol = 1'b0;
    tick();
    check("R11 raw", rawWord, 10'h15A);
    check("R11 rawValid", rawValid, 1'b1);
    dataIn = 8'h81; specialSel = 1'b0; sendViol = 1'b1;
    tick();
    check("R11 raw with violation bit", rawWord, 10'h281);
    check("R11 kind stays fill", charKind, 2'd2);
    idleInputs();
    tick();
    check("R11 rawValid drops", rawValid, 1'b0);

    done = 1'b1;
    finishRun();
  end

endmodule